// File: doc/BRIEF.md
# I2C Address Scanner

This block sweeps the full 7-bit target address range of an I2C bus and reports every bus byte that a target acknowledges. A single pulse on `start` launches a sweep. For each address, counted upward from zero, the scanner makes two probes: one with the write form of the address byte and one with the read form. Each probe consists of a START condition, the eight bits of the byte, a ninth clock on which the line is left to the target, and a STOP condition.

A probe that is acknowledged produces a one-cycle entry on the output stream. The entry carries the raw bus byte, the 7-bit address and a read flag. When a read-form probe is acknowledged, the target now owns the data line. The scanner therefore clocks one data byte out of it and refuses that byte before it sends STOP, which returns the bus to idle.

Presence is judged only by a low level on the data line during the ninth clock. A bus without pull-up resistors reads low at all times, so every probe looks acknowledged. The block does not try to detect this condition.

The bus pins are open-drain: an `*Oe` output at 1 pulls its line low. The bit timing comes from a quarter-bit counter whose length is a parameter.

Top module: `i2c_addr_scanner`

## Requirements
- R1: A sweep probes addresses 0 through 127 in increasing order. For each address the write form (read flag 0) is probed before the read form (read flag 1). Entries appear on the stream in that same order.
- R2: Each probe has four parts in this order. First, START: SDA falls while SCL is released high. Next, the bus byte {address, rwFlag} goes out MSB first. Then comes a ninth clock with SDA released. Last, STOP: SDA rises while SCL is high. Taken across a sweep, the probed bus bytes therefore run 0x00 to 0xFF in increasing order.
- R3: A probe counts as acknowledged only when SDA is low at the sampling point of the ninth clock. An acknowledged probe raises `outValid` for exactly one cycle, with `outByte` = {address, rwFlag}, `outAddr` = the address and `outRead` = rwFlag. While `outValid` is high, the scanner is not pulling SDA low.
- R4: After an acknowledged read-form probe, the scanner clocks eight more bits with SDA released. It then leaves SDA released on the ninth clock (a NACK). STOP follows. No other START comes before that STOP.
- R5: `busy` is high from the cycle after `start` is taken until the sweep ends. At the end of the last probe's STOP, `done` goes high for exactly one cycle, and `busy` falls in that same cycle. By the time `done` is raised, every entry of the sweep has already been emitted.
- R6: A `start` pulse that arrives while `busy` is high has no effect. The sweep carries on without restarting.
- R7: During reset and whenever `busy` is low, both lines are released and `outValid`, `done` and `busy` are 0.
- R8: With no pull-ups on the bus, every one of the 256 probes is reported as acknowledged. The block performs no check for a missing pull-up.
- R9: During every data and acknowledge bit, SCL is released for exactly 2*QTR_CYCLES clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins a sweep when idle |
| sdaIn | input | 1 | Sensed level of the data line |
| sclOe | output | 1 | 1 pulls the clock line low |
| sdaOe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| outValid | output | 1 | One-cycle strobe for a found bus byte |
| outByte | output | 8 | Raw bus byte that was acknowledged |
| outAddr | output | 7 | 7-bit address of the entry |
| outRead | output | 1 | 1 when the entry is the read form |

## Verification
The bench includes a target that decodes the bus. It acknowledges address 0 and address 127, the two ends of the range. It also has one address that acknowledges only its write form and one that acknowledges only its read form. A design that merged the two forms, or that stopped one short of 127, would therefore emit the wrong entries. A design that skipped the refused-byte phase after an acknowledged read would leave the target driving SDA during STOP, and the bench counts that as a broken read. A second `start` pulse is sent in the middle of the sweep: a scanner that restarted would break the strictly increasing sequence of probed bytes. One sweep runs with the pull-ups removed, and the bench expects all 256 entries from it; this shows that the scanner blindly reports every probe on a floating-low bus.

// File: rtl/i2cscan_pkg.sv
package i2cscan_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int FRAME_W = BYTE_W + 1;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_START,
    OP_BYTE,
    OP_STOP
  } busOp_e;

  typedef enum logic [2:0] {
    SC_IDLE,
    SC_START,
    SC_ADDR,
    SC_READ,
    SC_STOP
  } scanState_e;

  // Strobes from the sweep control to the bit engine
  typedef struct packed {
    logic               goStart;
    logic               goByte;
    logic               goStop;
    logic [FRAME_W-1:0] txBits;   // nine bits, MSB first; a 1 releases SDA
  } engCmd_t;

endpackage

// File: rtl/i2cscan_bitengine.sv
module i2cscan_bitengine
  import i2cscan_pkg::*;
#(
  parameter int QTR_CYCLES = 250
) (
  input  logic    clk,
  input  logic    rstN,
  input  engCmd_t cmd,
  input  logic    sdaIn,
  output logic    opDone,
  output logic    ackLow,
  output logic    sclOe,
  output logic    sdaOe
);

  localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] Q_LAST = CW'(QTR_CYCLES - 1);
  localparam logic [3:0] LAST_BIT = 4'(FRAME_W - 1);

  busOp_e             op;
  logic [CW-1:0]      qCnt;
  logic [1:0]         quarter;
  logic [3:0]         bitIdx;
  logic [FRAME_W-1:0] shiftReg;
  logic               sclHeld;
  logic               sdaHeld;

  logic qEnd;
  logic lastQ;

  assign qEnd  = (qCnt == Q_LAST);
  assign lastQ = (op == OP_BYTE) ? (quarter == 2'd3) : (quarter == 2'd2);
  assign opDone = (op != OP_IDLE) && qEnd && lastQ &&
                  ((op != OP_BYTE) || (bitIdx == LAST_BIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op       <= OP_IDLE;
      qCnt     <= '0;
      quarter  <= 2'd0;
      bitIdx   <= 4'd0;
      shiftReg <= '1;
      sclHeld  <= 1'b0;
      sdaHeld  <= 1'b0;
      ackLow   <= 1'b0;
    end else if (op == OP_IDLE) begin
      qCnt    <= '0;
      quarter <= 2'd0;
      if (cmd.goStart) begin
        op <= OP_START;
      end else if (cmd.goByte) begin
        op       <= OP_BYTE;
        shiftReg <= cmd.txBits;
        bitIdx   <= 4'd0;
      end else if (cmd.goStop) begin
        op <= OP_STOP;
      end
    end else if (!qEnd) begin
      qCnt <= qCnt + 1'b1;
    end else begin
      qCnt <= '0;
      // sample the line in the middle of the SCL high time of the ninth bit
      if (op == OP_BYTE && quarter == 2'd1 && bitIdx == LAST_BIT) begin
        ackLow <= ~sdaIn;
      end
      if (!lastQ) begin
        quarter <= quarter + 2'd1;
      end else begin
        quarter <= 2'd0;
        if (op == OP_BYTE) begin
          shiftReg <= {shiftReg[FRAME_W-2:0], 1'b1};
          if (bitIdx == LAST_BIT) begin
            op      <= OP_IDLE;
            sclHeld <= 1'b1;
            sdaHeld <= ~shiftReg[FRAME_W-1];
          end else begin
            bitIdx <= bitIdx + 4'd1;
          end
        end else begin
          op      <= OP_IDLE;
          sclHeld <= (op == OP_START);
          sdaHeld <= (op == OP_START);
        end
      end
    end
  end

  // Open-drain line drive decoded from the quarter position
  always_comb begin
    unique case (op)
      OP_START: begin
        sclOe = (quarter == 2'd2);
        sdaOe = (quarter != 2'd0);
      end
      OP_BYTE: begin
        sclOe = (quarter == 2'd0) || (quarter == 2'd3);
        sdaOe = ~shiftReg[FRAME_W-1];
      end
      OP_STOP: begin
        sclOe = (quarter == 2'd0);
        sdaOe = (quarter != 2'd2);
      end
      default: begin
        sclOe = sclHeld;
        sdaOe = sdaHeld;
      end
    endcase
  end

endmodule

// File: rtl/i2cscan_control.sv
module i2cscan_control
  import i2cscan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opDone,
  input  logic              ackLow,
  output engCmd_t           cmd,
  output logic              busy,
  output logic              done,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outRead
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  scanState_e        state;
  logic [ADDR_W-1:0] addr;
  logic              rwBit;
  logic              waitOp;
  logic              issue;

  assign busy  = (state != SC_IDLE);
  assign issue = busy && !waitOp;

  always_comb begin
    cmd.goStart = issue && (state == SC_START);
    cmd.goByte  = issue && ((state == SC_ADDR) || (state == SC_READ));
    cmd.goStop  = issue && (state == SC_STOP);
    cmd.txBits  = (state == SC_READ) ? '1 : {addr, rwBit, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SC_IDLE;
      addr     <= '0;
      rwBit    <= 1'b0;
      waitOp   <= 1'b0;
      done     <= 1'b0;
      outValid <= 1'b0;
      outByte  <= '0;
      outAddr  <= '0;
      outRead  <= 1'b0;
    end else begin
      done     <= 1'b0;
      outValid <= 1'b0;
      if (issue) begin
        waitOp <= 1'b1;
      end
      if (state == SC_IDLE) begin
        if (start) begin
          state <= SC_START;
          addr  <= '0;
          rwBit <= 1'b0;
        end
      end else if (opDone) begin
        waitOp <= 1'b0;
        unique case (state)
          SC_START: state <= SC_ADDR;
          SC_ADDR: begin
            if (ackLow) begin
              outValid <= 1'b1;
              outByte  <= {addr, rwBit};
              outAddr  <= addr;
              outRead  <= rwBit;
            end
            state <= (ackLow && rwBit) ? SC_READ : SC_STOP;
          end
          SC_READ: state <= SC_STOP;
          SC_STOP: begin
            if (!rwBit) begin
              rwBit <= 1'b1;
              state <= SC_START;
            end else if (addr == LAST_ADDR) begin
              done  <= 1'b1;
              state <= SC_IDLE;
            end else begin
              addr  <= addr + 1'b1;
              rwBit <= 1'b0;
              state <= SC_START;
            end
          end
          default: state <= SC_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_addr_scanner.sv
module i2c_addr_scanner
  import i2cscan_pkg::*;
#(
  parameter int QTR_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       busy,
  output logic       done,
  output logic       outValid,
  output logic [7:0] outByte,
  output logic [6:0] outAddr,
  output logic       outRead
);

  engCmd_t engCmd;
  logic    opDone;
  logic    ackLow;

  i2cscan_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opDone   (opDone),
    .ackLow   (ackLow),
    .cmd      (engCmd),
    .busy     (busy),
    .done     (done),
    .outValid (outValid),
    .outByte  (outByte),
    .outAddr  (outAddr),
    .outRead  (outRead)
  );

  i2cscan_bitengine #(
    .QTR_CYCLES (QTR_CYCLES)
  ) u_engine (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (engCmd),
    .sdaIn  (sdaIn),
    .opDone (opDone),
    .ackLow (ackLow),
    .sclOe  (sclOe),
    .sdaOe  (sdaOe)
  );

endmodule

// File: rtl/i2cscan_checks.sv
module i2cscan_checks (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic outValid,
  input logic sclOe,
  input logic sdaOe
);

  p_idle_released_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe));

  p_entry_in_sweep_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (busy && !sdaOe));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_when_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_end_only_by_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

bind i2c_addr_scanner i2cscan_checks u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .done     (done),
  .outValid (outValid),
  .sclOe    (sclOe),
  .sdaOe    (sdaOe)
);

// File: tb/test_i2c_addr_scanner.sv
module test_i2c_addr_scanner;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int QTR = 2;
  localparam logic [7:0] RD_DATA = 8'hA5;

  logic clk = 1'b0;
  logic rstN;
  logic start;
  logic sdaIn;
  logic sclOe, sdaOe, busy, done, outValid, outRead;
  logic [7:0] outByte;
  logic [6:0] outAddr;

  logic pullOn;
  logic tgtLow;
  logic sclLine, sdaLine;

  always #4 clk = ~clk;

  assign sclLine = pullOn ? ~sclOe : 1'b0;
  assign sdaLine = pullOn ? ~(sdaOe | tgtLow) : 1'b0;
  assign sdaIn   = sdaLine;

  i2c_addr_scanner #(.QTR_CYCLES(QTR)) i_i2c_addr_scanner (
    .clk(clk), .rstN(rstN), .start(start), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .done(done),
    .outValid(outValid), .outByte(outByte), .outAddr(outAddr), .outRead(outRead)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // targets present on the bus
  function automatic bit ackFor(input logic [7:0] b);
    logic [6:0] a;
    a = b[7:1];
    return (a == 7'h00) || (a == 7'h68) ||
           (a == 7'h3C && !b[0]) || (a == 7'h7F && b[0]);
  endfunction

  // ---------------- scoreboard ----------------
  logic [7:0] expQ[$];
  int entryCnt, doneCnt, doneWide;
  bit prevDone = 1'b0;

  always @(negedge clk) begin
    if (outValid) begin
      entryCnt++;
      if (expQ.size() == 0) begin
        check(1'b0, "R1", "unexpected entry", int'(outByte), 0);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(outByte == e, "R1", "entry byte", int'(outByte), int'(e));
        check(outAddr == e[7:1] && outRead == e[0], "R3", "entry fields",
              int'({outAddr, outRead}), int'(e));
      end
    end
    if (done) begin
      doneCnt++;
      check(!busy, "R5", "busy at done", int'(busy), 0);
      check(expQ.size() == 0, "R5", "entries left at done", expQ.size(), 0);
    end
    if (done && prevDone) doneWide++;
    prevDone = done;
  end

  // ---------------- target model ----------------
  typedef enum {T_IDLE, T_ADR, T_RD, T_WAIT} tPhase_e;
  tPhase_e phase = T_IDLE;
  bit pScl = 1'b1, pSda = 1'b1;
  int bitCnt;
  logic [7:0] shiftIn;
  logic [7:0] probeExp;
  int probes, probeBad, readsDone, readBad, widthBad, hiCnt;
  bit measuring;

  always @(negedge clk) begin
    bit sc, sd;
    sc = sclLine;
    sd = sdaLine;
    if (pScl && sc && pSda && !sd) begin
      if (phase == T_RD) readBad++;
      phase = T_ADR; bitCnt = 0; shiftIn = 8'h00; tgtLow = 1'b0;
    end else if (pScl && sc && !pSda && sd) begin
      if (phase == T_RD) readBad++;
      phase = T_IDLE; tgtLow = 1'b0;
    end else if (!pScl && sc) begin
      if (phase == T_ADR || phase == T_RD) begin
        measuring = 1'b1; hiCnt = 1;
      end
      if (phase == T_ADR && bitCnt < 8) shiftIn = {shiftIn[6:0], sd};
      if (phase == T_RD && bitCnt < 8 && sdaOe) readBad++;
      if (phase == T_RD && bitCnt == 8 && !sd) readBad++;
      bitCnt++;
      if (phase == T_ADR && bitCnt == 8) begin
        probes++;
        if (shiftIn != probeExp) probeBad++;
        probeExp = probeExp + 8'd1;
      end
    end else if (pScl && !sc) begin
      if (measuring && hiCnt != 2 * QTR) widthBad++;
      measuring = 1'b0;
      if (phase == T_ADR) begin
        if (bitCnt == 8) begin
          tgtLow = ackFor(shiftIn);
        end else if (bitCnt == 9) begin
          tgtLow = 1'b0;
          if (shiftIn[0] && ackFor(shiftIn)) begin
            phase = T_RD; bitCnt = 0; tgtLow = !RD_DATA[7];
          end else begin
            phase = T_WAIT;
          end
        end
      end else if (phase == T_RD) begin
        if (bitCnt < 8) begin
          tgtLow = !RD_DATA[3'(7 - bitCnt)];
        end else if (bitCnt == 8) begin
          tgtLow = 1'b0;
        end else begin
          tgtLow = 1'b0; phase = T_WAIT; readsDone++;
        end
      end
    end else if (sc && measuring) begin
      hiCnt++;
    end
    pScl = sc;
    pSda = sd;
  end

  // ---------------- driver ----------------
  task automatic runSweep(input bit pull, input bit midPulse);
    pullOn = pull;
    entryCnt = 0; doneCnt = 0; doneWide = 0;
    probes = 0; probeBad = 0; readsDone = 0; readBad = 0; widthBad = 0;
    probeExp = 8'h00;
    for (int i = 0; i < 256; i++) begin
      if (!pull || ackFor(8'(i))) expQ.push_back(8'(i));
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R5", "busy after start", int'(busy), 1);
    if (midPulse) begin
      repeat (3000) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy == 1'b1, "R6", "busy after second start", int'(busy), 1);
    end
    while (doneCnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(doneCnt == 1, "R5", "done pulses", doneCnt, 1);
    check(doneWide == 0, "R5", "done wider than one cycle", doneWide, 0);
    check(!sclOe && !sdaOe && !busy, "R7", "idle lines after sweep",
          int'({sclOe, sdaOe, busy}), 0);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; pullOn = 1'b1; tgtLow = 1'b0;
    repeat (4) @(negedge clk);
    check({sclOe, sdaOe, busy, done, outValid} == 5'b0, "R7", "reset outputs",
          int'({sclOe, sdaOe, busy, done, outValid}), 0);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    check({sclOe, sdaOe, busy} == 3'b0, "R7", "idle after reset",
          int'({sclOe, sdaOe, busy}), 0);

    // sweep with pull-ups and a stray start pulse in the middle
    runSweep(1'b1, 1'b1);
    check(entryCnt == 6, "R3", "entry count with targets", entryCnt, 6);
    check(probes == 256, "R2", "probes decoded", probes, 256);
    check(probeBad == 0, "R2", "probe byte sequence breaks (R6 restart)", probeBad, 0);
    check(readsDone == 3, "R4", "refused read bytes", readsDone, 3);
    check(readBad == 0, "R4", "read phase violations", readBad, 0);
    check(widthBad == 0, "R9", "SCL high width errors", widthBad, 0);

    // sweep with no pull-ups: everything reads as acknowledged
    runSweep(1'b0, 1'b0);
    check(entryCnt == 256, "R8", "entries without pull-ups", entryCnt, 256);

    // back to a healthy bus
    runSweep(1'b1, 1'b0);
    check(entryCnt == 6, "R1", "entry count after recovery", entryCnt, 6);
    check(probeBad == 0 && probes == 256, "R2", "probe sequence after recovery",
          probeBad, 0);
    check(readsDone == 3 && readBad == 0, "R4", "reads after recovery", readBad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected sweep completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule